// File: doc/BRIEF.md
# Double-Buffered Transmit Handoff Controller

This block is the device-side handoff logic for transmit frames that a host copies into one of two fixed buffers in device memory. It keeps a producer count, advanced by host doorbell pulses, and a consumer count, advanced once the device has finished with a buffer. Both counts are 4 bits wide. The host reads the consumer count from a status word. It may copy a new frame only while the modulo-16 difference between the counts is below two. Frames alternate between the two buffers, and the count's least significant bit selects the buffer.

Whenever the counts differ, the controller fetches the 16-byte descriptor at the head of the buffer the consumer count selects. It reads the descriptor as four 32-bit little-endian words from a memory with one cycle of read latency. It then presents the decoded fields until the downstream engine reports that the buffer is drained. At that point it pulses a release strobe naming the freed buffer and advances the consumer count.

Top module: `dbuf_tx_handoff`

## Requirements
- R1: After reset, `status_word` is 0, `tx_room` is 1, `host_buf` is 0, `desc_valid` is 0 and `mem_rd` is 0.
- R2: A `host_doorbell` pulse while `tx_room` is 1 advances the producer count by one, so `host_buf` (the producer count's LSB) toggles.
- R3: `tx_room` is 1 exactly when (producer − consumer) mod 16 is less than 2. A doorbell while `tx_room` is 0 is ignored, and no extra frame is ever presented for it.
- R4: `status_word[3:0]` holds the consumer count and the upper bits read 0.
- R5: While the counts differ, the block reads descriptor words 0 to 3 in order with `mem_rdata` valid one cycle after `mem_rd`. `mem_addr` is {consumer LSB, word index}, so the buffer read is the one the consumer count selects.
- R6: The descriptor fields decode as follows. Word 0 holds length in [15:0] and rate mask in [31:16]. Word 1 holds the expiry time. Word 2 holds queue index in [7:0], frame id in [15:8] and control in [31:16]. Word 3 holds fragment threshold in [15:0] and memory block count in [23:16]. Bits [31:24] of word 3 are ignored.
- R7: The control halfword yields rate policy in [2:0], no-ack in [3], packet type in [5:4] (0 = 802.11, 1 = 802.3, 2 = IP, 3 = raw), QoS in [6], completion request in [7] and transfer pad in [8]. Bits [15:9] are ignored.
- R8: `frm_len_al` equals the length rounded up to a multiple of 4, modulo 2^16.
- R9: `rate_err` is 1 unless the rate mask has exactly one bit set among bits 0 to 12.
- R10: `drain_done` while `desc_valid` is 1 gives a same-cycle `release_pulse` with `release_buf` equal to the consumer LSB, and advances the consumer count. `drain_done` at any other time is ignored.
- R11: Both counts wrap modulo 16 without disturbing the flow control or buffer alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_doorbell | input | 1 | Host announces one copied frame |
| status_word | output | 8 | Consumer count in bits [3:0] |
| tx_room | output | 1 | Host may copy another frame |
| host_buf | output | 1 | Buffer the host fills next |
| mem_rd | output | 1 | Descriptor word read strobe |
| mem_addr | output | 3 | {buffer, word index} |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |
| desc_valid | output | 1 | Decoded descriptor is presented |
| frm_len | output | 16 | Frame length including headers |
| frm_len_al | output | 16 | Length rounded up to 4 bytes |
| frm_rate | output | 16 | Initial-rate mask |
| rate_err | output | 1 | Rate mask is not a legal one-hot value |
| expiry_us | output | 32 | Expiry time in microseconds |
| queue_idx | output | 8 | Transmit queue index |
| frame_id | output | 8 | Frame identifier |
| rate_policy | output | 3 | Rate policy class |
| no_ack | output | 1 | No acknowledgement expected |
| pkt_type | output | 2 | Packet type code |
| qos | output | 1 | QoS frame |
| cpl_req | output | 1 | Completion report requested |
| xfer_pad | output | 1 | Two pad bytes precede the header |
| frag_thr | output | 16 | Fragment threshold |
| mem_blocks | output | 8 | Memory block count |
| drain_done | input | 1 | Downstream has finished the buffer |
| release_pulse | output | 1 | Buffer released this cycle |
| release_buf | output | 1 | Index of the released buffer |

## Verification
The embedded properties check on every cycle that occupancy never exceeds two and that a doorbell with room advances the producer count. They also check that every read targets the consumer's buffer, that a release advances the consumer count, and that a descriptor presented without an error flag carries a one-hot rate. Only the bench scenarios can show that field decoding is correct, which needs known memory contents. The same holds for length rounding including wrap at the top of the range, for rejection of each class of illegal rate, for ignored doorbells and stray drain strobes producing no extra frame, and for alternation holding across two wraps of the counts.

// File: rtl/dbuf_tx_handoff.sv
module dbuf_tx_handoff #(
  parameter int CNT_W  = 4,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_doorbell,
  output logic [STAT_W-1:0] status_word,
  output logic              tx_room,
  output logic              host_buf,
  output logic              mem_rd,
  output logic [2:0]        mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              desc_valid,
  output logic [15:0]       frm_len,
  output logic [15:0]       frm_len_al,
  output logic [15:0]       frm_rate,
  output logic              rate_err,
  output logic [31:0]       expiry_us,
  output logic [7:0]        queue_idx,
  output logic [7:0]        frame_id,
  output logic [2:0]        rate_policy,
  output logic              no_ack,
  output logic [1:0]        pkt_type,
  output logic              qos,
  output logic              cpl_req,
  output logic              xfer_pad,
  output logic [15:0]       frag_thr,
  output logic [7:0]        mem_blocks,
  input  logic              drain_done,
  output logic              release_pulse,
  output logic              release_buf
);
  localparam int NBUF      = 2;
  localparam int DWORDS    = 4;
  localparam int WIDX_W    = $clog2(DWORDS);
  localparam int RATE_BITS = 13;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LAST, S_HOLD} state_t;

  state_t            state;
  logic [CNT_W-1:0]  prod, cons, occ;
  logic [WIDX_W-1:0] fetch_idx, cap_idx;
  logic              cap_v;
  logic [31:0]       desc_q [DWORDS];
  logic [15:0]       ctrl;

  assign occ         = prod - cons;
  assign tx_room     = occ < CNT_W'(NBUF);
  assign host_buf    = prod[0];
  assign status_word = STAT_W'(cons);

  assign mem_rd   = (state == S_FETCH);
  assign mem_addr = {cons[0], fetch_idx};

  assign desc_valid    = (state == S_HOLD);
  assign release_pulse = desc_valid && drain_done;
  assign release_buf   = cons[0];

  assign frm_len    = desc_q[0][15:0];
  assign frm_rate   = desc_q[0][31:16];
  assign expiry_us  = desc_q[1];
  assign queue_idx  = desc_q[2][7:0];
  assign frame_id   = desc_q[2][15:8];
  assign ctrl       = desc_q[2][31:16];
  assign frag_thr   = desc_q[3][15:0];
  assign mem_blocks = desc_q[3][23:16];

  assign rate_policy = ctrl[2:0];
  assign no_ack      = ctrl[3];
  assign pkt_type    = ctrl[5:4];
  assign qos         = ctrl[6];
  assign cpl_req     = ctrl[7];
  assign xfer_pad    = ctrl[8];

  assign frm_len_al = (frm_len + 16'd3) & ~16'd3;
  assign rate_err   = (frm_rate == 16'd0) || ((frm_rate & (frm_rate - 16'd1)) != 16'd0)
                      || (|frm_rate[15:RATE_BITS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      prod      <= '0;
      cons      <= '0;
      fetch_idx <= '0;
      cap_idx   <= '0;
      cap_v     <= 1'b0;
      for (int i = 0; i < DWORDS; i++) desc_q[i] <= '0;
    end else begin
      if (host_doorbell && tx_room) prod <= prod + 1'b1;
      cap_v   <= mem_rd;
      cap_idx <= fetch_idx;
      if (cap_v) desc_q[cap_idx] <= mem_rdata;
      case (state)
        S_IDLE:  if (prod != cons) begin
                   state     <= S_FETCH;
                   fetch_idx <= '0;
                 end
        S_FETCH: begin
                   fetch_idx <= fetch_idx + 1'b1;
                   if (fetch_idx == WIDX_W'(DWORDS - 1)) state <= S_LAST;
                 end
        S_LAST:  state <= S_HOLD;
        S_HOLD:  if (drain_done) begin
                   cons  <= cons + 1'b1;
                   state <= S_IDLE;
                 end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(NBUF));

  a_r2_doorbell_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (host_doorbell && tx_room) |=> (host_buf != $past(host_buf)));

  a_r5_reads_consumer_buf: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[2] == status_word[0]));

  a_r10_release_advances: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> (status_word[CNT_W-1:0] == $past(status_word[CNT_W-1:0]) + 1'b1));

  a_r9_legal_rate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !rate_err) |-> ($countones(frm_rate[RATE_BITS-1:0]) == 1));
endmodule

// File: tb/dbuf_tx_handoff_bench.sv
module dbuf_tx_handoff_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_doorbell = 1'b0;
  logic        drain_done = 1'b0;
  logic [7:0]  status_word;
  logic        tx_room, host_buf, mem_rd, desc_valid, rate_err;
  logic [2:0]  mem_addr;
  logic [31:0] mem_rdata, expiry_us;
  logic [15:0] frm_len, frm_len_al, frm_rate, frag_thr;
  logic [7:0]  queue_idx, frame_id, mem_blocks;
  logic [2:0]  rate_policy;
  logic        no_ack, qos, cpl_req, xfer_pad, release_pulse, release_buf;
  logic [1:0]  pkt_type;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int m_cons  = 0;
  logic [31:0] mem [8];

  always #2 clk = ~clk;

  dbuf_tx_handoff u_dbuf_tx_handoff (
    .clk(clk), .rst_n(rst_n), .host_doorbell(host_doorbell),
    .status_word(status_word), .tx_room(tx_room), .host_buf(host_buf),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .desc_valid(desc_valid), .frm_len(frm_len), .frm_len_al(frm_len_al),
    .frm_rate(frm_rate), .rate_err(rate_err), .expiry_us(expiry_us),
    .queue_idx(queue_idx), .frame_id(frame_id), .rate_policy(rate_policy),
    .no_ack(no_ack), .pkt_type(pkt_type), .qos(qos), .cpl_req(cpl_req),
    .xfer_pad(xfer_pad), .frag_thr(frag_thr), .mem_blocks(mem_blocks),
    .drain_done(drain_done), .release_pulse(release_pulse), .release_buf(release_buf)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int widx = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        chk(mem_addr[2] == m_cons[0], "R5 buffer", mem_addr[2], m_cons[0]);
        chk(mem_addr[1:0] == widx[1:0], "R5 word order", mem_addr[1:0], widx[1:0]);
        widx = (widx + 1) % 4;
      end
    end
  end

  function automatic logic [15:0] f_len(int i);
    return (i % 7 == 6) ? 16'hFFFE : 16'((i * 1237 + 5) & 16'hFFFF);
  endfunction
  function automatic logic [15:0] f_rate(int i);
    int k = i % 16;
    if (k < 13) return 16'(1 << k);
    if (k == 13) return 16'h0000;
    if (k == 14) return 16'h0003;
    return 16'h2000;
  endfunction
  function automatic logic [15:0] f_ctrl(int i);
    return 16'(((i * 83 + 7) & 16'h01FF) | ((i % 2 == 1) ? 16'hFE00 : 16'h0000));
  endfunction

  task automatic load_frame(input int i, input int b);
    mem[b*4+0] = {f_rate(i), f_len(i)};
    mem[b*4+1] = (32'(i) * 32'h01010101) ^ 32'hA5A50000;
    mem[b*4+2] = {f_ctrl(i), 8'(i + 8'h40), 8'(i % 4)};
    mem[b*4+3] = {8'hEE, 8'(i * 3 + 1), 16'(i * 300)};
  endtask

  task automatic ring();
    @(negedge clk) host_doorbell = 1'b1;
    @(negedge clk) host_doorbell = 1'b0;
  endtask

  task automatic consume(input int i);
    logic [15:0] ctl, ln;
    int k, to;
    to = 0;
    while (!desc_valid && to < 100) begin @(negedge clk); to++; end
    chk(desc_valid, "R5 descriptor presented", desc_valid, 1);
    ctl = f_ctrl(i);
    ln  = f_len(i);
    k   = i % 16;
    chk(frm_len == ln, "R6 length", frm_len, ln);
    chk(frm_rate == f_rate(i), "R6 rate", frm_rate, f_rate(i));
    chk(expiry_us == ((32'(i) * 32'h01010101) ^ 32'hA5A50000), "R6 expiry", expiry_us,
        (32'(i) * 32'h01010101) ^ 32'hA5A50000);
    chk(queue_idx == 8'(i % 4), "R6 queue", queue_idx, i % 4);
    chk(frame_id == 8'(i + 8'h40), "R6 id", frame_id, 8'(i + 8'h40));
    chk(frag_thr == 16'(i * 300), "R6 frag", frag_thr, 16'(i * 300));
    chk(mem_blocks == 8'(i * 3 + 1), "R6 blocks", mem_blocks, 8'(i * 3 + 1));
    chk({xfer_pad, cpl_req, qos, pkt_type, no_ack, rate_policy} == ctl[8:0], "R7 control",
        {xfer_pad, cpl_req, qos, pkt_type, no_ack, rate_policy}, ctl[8:0]);
    chk(frm_len_al == 16'((32'(ln) + 3) & 32'hFFFC), "R8 align", frm_len_al,
        16'((32'(ln) + 3) & 32'hFFFC));
    chk(rate_err == (k >= 13), "R9 rate error", rate_err, k >= 13);
    drain_done = 1'b1;
    #1;
    chk(release_pulse && release_buf == m_cons[0], "R10 release", {release_pulse, release_buf},
        {1'b1, m_cons[0]});
    @(negedge clk) drain_done = 1'b0;
    m_cons = (m_cons + 1) % 16;
    chk(status_word == 8'(m_cons), "R4 R11 status", status_word, m_cons);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(status_word == 8'd0 && tx_room && !host_buf && !desc_valid && !mem_rd, "R1 reset",
        {status_word, tx_room, host_buf, desc_valid, mem_rd}, 8'h0 << 4 | 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int it = 0; it < 20; it++) begin
      int hb;
      hb = host_buf;
      load_frame(2*it, hb);
      ring();
      chk(host_buf == !hb[0], "R2 toggle", host_buf, !hb[0]);
      load_frame(2*it + 1, !hb[0]);
      ring();
      chk(host_buf == hb[0], "R2 toggle", host_buf, hb[0]);
      chk(!tx_room, "R3 full", tx_room, 0);
      ring();
      chk(host_buf == hb[0], "R3 ignored doorbell", host_buf, hb[0]);
      consume(2*it);
      chk(tx_room, "R3 room after release", tx_room, 1);
      consume(2*it + 1);
      repeat (12) @(negedge clk);
      chk(!desc_valid && !mem_rd, "R3 no extra frame", desc_valid, 0);
      @(negedge clk) drain_done = 1'b1;
      #1;
      chk(!release_pulse, "R10 stray drain", release_pulse, 0);
      @(negedge clk) drain_done = 1'b0;
      chk(status_word == 8'(m_cons) && tx_room, "R10 stray drain status", status_word, m_cons);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule